// File: doc/BRIEF.md
# Stuck-SDA I2C Bus Recovery Controller

This block sits beside an I2C controller and runs once when initialization begins. A target device that was left partway through a read may still be holding SDA low while it waits for clock edges that will not arrive. On a start pulse the block samples the bus. If SDA is already high, the bus is free and the block reports success at once. If SDA is low, the block clocks SCL until the target lets go of SDA, and then it closes the bus with a STOP condition.

The bus is handled as open-drain. Each line has an output enable that pulls it low when set and releases it when clear. Neither line is ever driven high. Both line inputs pass through a two-flop synchronizer before any decision is made on them. The SCL half-period is set in clock cycles by an input. The block issues at most nine pulses, which covers one data byte plus its acknowledge bit. It then reports done together with either recovered or failed, and it gives the number of pulses it issued.

Top module: `sda_release_ctrl`

## Requirements
- R1: If synchronized SDA reads high when a start is accepted, the block ends with done and recovered set and pulseCount 0. It never asserts sclOe or sdaOe in that run.
- R2: Each recovery pulse holds sclOe high for exactly halfPeriod cycles. When the bus is not stretched, SCL then stays released for halfPeriod+2 cycles, because of the synchronizer delay.
- R3: SDA is sampled at the end of each SCL-high phase. The first time it reads high, pulsing stops, and pulseCount equals the number of pulses issued. A target that needs N pulses (1 to 8) gives pulseCount N.
- R4: At most 9 pulses are issued. A target that needs the full 9 pulses recovers with pulseCount 9. If SDA is still low after the ninth pulse, the block ends with done and failed set and pulseCount 9, and leaves both lines released with no STOP.
- R5: After SDA is freed, the block drives SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high. This forms a STOP. SDA is never pulled low while SCL is high. The run ends with recovered set.
- R6: busy rises in the cycle after an accepted start and stays high until done. A start that arrives while busy has no effect on the run.
- R7: done is a single-cycle pulse. recovered and failed never both hold, keep their value until the next accepted start, and are all clear after reset.
- R8: Both line inputs pass through two flops. The SCL-high timer counts only while the synchronized SCL reads high, so a target that stretches SCL low delays the sample point. With stretching, the SCL line is still high for halfPeriod+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to check and recover the bus |
| halfPeriod | input | HALF_W | SCL half-period in clock cycles |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Check or recovery in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| recovered | output | 1 | Last run ended with SDA free |
| failed | output | 1 | Last run ended with SDA still low after nine pulses |
| pulseCount | output | 4 | Pulses issued in the current or last run |

## Verification
A controller stuck in the wrong phase shows up on the lines within one half-period. An SCL low phase of the wrong length, SDA pulled low while SCL is high, or a STOP whose edges are out of order are all seen on the next transition. A wrong pulse counter or a wrong exit test shows up at done, as a pulseCount that differs from the number of edges the bench target needed, or as recovered and failed swapped. Synchronizer or stretch-handling faults change the width of the measured SCL-high phase by at least one cycle.

// File: rtl/sda_release_pkg.sv
package sda_release_pkg;
  localparam int unsigned MaxPulses  = 9;
  localparam int unsigned CountW     = $clog2(MaxPulses + 1);
  localparam int unsigned SyncStages = 2;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic cntClr;
    logic cntInc;
  } dpCtrl_t;

  typedef enum logic [3:0] {
    StIdle, StCheck, StPulseLow, StPulseHigh,
    StStopLow, StStopHold, StStopRise, StDoneOk, StDoneFail
  } recState_t;
endpackage

// File: rtl/sda_release_dp.sv
module sda_release_dp
  import sda_release_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclHigh,
  output logic              sdaHigh,
  output logic              halfDone,
  output logic [CountW-1:0] pulseCount
);
  // bit 1 carries SCL, bit 0 carries SDA
  logic [1:0] syncPipe [SyncStages];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SyncStages; i++) syncPipe[i] <= 2'b11;
    end else begin
      syncPipe[0] <= {sclIn, sdaIn};
      for (int i = 1; i < SyncStages; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign sclHigh = syncPipe[SyncStages-1][1];
  assign sdaHigh = syncPipe[SyncStages-1][0];

  logic [HALF_W-1:0] timerCnt;
  logic [HALF_W:0]   nextTick;
  assign nextTick = {1'b0, timerCnt} + {{HALF_W{1'b0}}, 1'b1};
  assign halfDone = nextTick >= {1'b0, halfPeriod};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerCnt <= '0;
    else if (ctrl.timerClr) timerCnt <= '0;
    else if (ctrl.timerRun) timerCnt <= timerCnt + {{(HALF_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pulseCount <= '0;
    else if (ctrl.cntClr) pulseCount <= '0;
    else if (ctrl.cntInc) pulseCount <= pulseCount + CountW'(1);
  end

  // R4: the pulse counter never passes the limit
  assert_count_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    pulseCount <= CountW'(MaxPulses));

  // R3: the counter only steps up by one or returns to zero
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCount != $past(pulseCount)) |->
      (pulseCount == '0 || pulseCount == $past(pulseCount) + CountW'(1)));
endmodule

// File: rtl/sda_release_fsm.sv
module sda_release_fsm
  import sda_release_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sclHigh,
  input  logic              sdaHigh,
  input  logic              halfDone,
  input  logic [CountW-1:0] pulseCount,
  output dpCtrl_t           ctrl,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              done,
  output logic              recovered,
  output logic              failed
);
  recState_t state, nextState;

  always_comb begin
    nextState     = state;
    ctrl          = '0;
    unique case (state)
      StIdle: if (start) begin
        nextState   = StCheck;
        ctrl.cntClr = 1'b1;
      end
      StCheck: nextState = sdaHigh ? StDoneOk : StPulseLow;
      StPulseLow: begin
        ctrl.timerRun = 1'b1;
        if (halfDone) begin
          nextState   = StPulseHigh;
          ctrl.cntInc = 1'b1;
        end
      end
      StPulseHigh: begin
        ctrl.timerRun = sclHigh;
        if (halfDone && sclHigh) begin
          if (sdaHigh)                               nextState = StStopLow;
          else if (pulseCount >= CountW'(MaxPulses)) nextState = StDoneFail;
          else                                       nextState = StPulseLow;
        end
      end
      StStopLow: begin
        ctrl.timerRun = 1'b1;
        if (halfDone) nextState = StStopHold;
      end
      StStopHold: begin
        ctrl.timerRun = 1'b1;
        if (halfDone) nextState = StStopRise;
      end
      StStopRise: begin
        ctrl.timerRun = sclHigh;
        if (halfDone && sclHigh) nextState = StDoneOk;
      end
      StDoneOk, StDoneFail: nextState = StIdle;
      default: nextState = StIdle;
    endcase
    ctrl.timerClr = (nextState != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= StIdle;
      recovered <= 1'b0;
      failed    <= 1'b0;
    end else begin
      state <= nextState;
      if (state == StIdle && start) begin
        recovered <= 1'b0;
        failed    <= 1'b0;
      end else if (nextState == StDoneOk && state != StDoneOk) begin
        recovered <= 1'b1;
      end else if (nextState == StDoneFail && state != StDoneFail) begin
        failed <= 1'b1;
      end
    end
  end

  assign sclOe = (state == StPulseLow) || (state == StStopLow) || (state == StStopHold);
  assign sdaOe = (state == StStopHold) || (state == StStopRise);
  assign busy  = (state != StIdle);
  assign done  = (state == StDoneOk) || (state == StDoneFail);

  // R6: an accepted start makes the block busy on the next cycle
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: the two result flags exclude each other
  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(recovered && failed));

  // R5: SDA is let go only while SCL is released
  assert_stop_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclOe);

  // R4: failure is reported only after the full pulse budget
  assert_fail_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failed) |-> (pulseCount == CountW'(MaxPulses)));
endmodule

// File: rtl/sda_release_ctrl.sv
module sda_release_ctrl
  import sda_release_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              done,
  output logic              recovered,
  output logic              failed,
  output logic [CountW-1:0] pulseCount
);
  dpCtrl_t ctrl;
  logic    sclHigh, sdaHigh, halfDone;

  sda_release_dp #(.HALF_W(HALF_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .halfPeriod(halfPeriod),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclHigh(sclHigh), .sdaHigh(sdaHigh),
    .halfDone(halfDone), .pulseCount(pulseCount)
  );

  sda_release_fsm uFsm (
    .clk(clk), .rstN(rstN), .start(start), .sclHigh(sclHigh),
    .sdaHigh(sdaHigh), .halfDone(halfDone), .pulseCount(pulseCount),
    .ctrl(ctrl), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done),
    .recovered(recovered), .failed(failed)
  );
endmodule

// File: tb/sda_release_ctrl_test.sv
`timescale 1ns/1ps
module sda_release_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] halfPeriod = 16'd4;
  logic        sclOe, sdaOe, busy, done, recovered, failed;
  logic [3:0]  pulseCount;
  logic        sclLine, sdaLine;

  // bench target: holds SDA until it sees tgtNeed rising SCL edges
  logic holdSda = 1'b0, holdScl = 1'b0, prevScl = 1'b1, stretchArm = 1'b0;
  int   tgtNeed = 0, tgtEdges = 0, stretchLen = 0, stretchCnt = 0;

  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  assign sclLine = !sclOe && !holdScl;
  assign sdaLine = !sdaOe && !holdSda;

  sda_release_ctrl uut (
    .clk(clk), .rstN(rstN), .start(start), .halfPeriod(halfPeriod),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .busy(busy), .done(done), .recovered(recovered), .failed(failed),
    .pulseCount(pulseCount)
  );

  always @(posedge clk) begin
    prevScl <= sclLine;
    if (sclLine && !prevScl && holdSda) begin
      tgtEdges <= tgtEdges + 1;
      if (tgtEdges + 1 == tgtNeed) holdSda <= 1'b0;
    end
    if (stretchArm && sclOe) begin
      holdScl    <= 1'b1;
      stretchCnt <= 0;
    end else if (holdScl && !sclOe) begin
      if (stretchCnt == stretchLen - 1) begin
        holdScl    <= 1'b0;
        stretchArm <= 1'b0;
      end
      stretchCnt <= stretchCnt + 1;
    end
  end

  // line monitors, sampled away from the active edge
  int firstLow, curLow, highWidth, doneSeen;
  bit sclDriven, stopSeen, badSdaFall, prevSdaOe;
  always @(negedge clk) begin
    if (sclOe) begin
      sclDriven = 1;
      curLow++;
    end else if (curLow > 0) begin
      if (firstLow < 0) firstLow = curLow;
      curLow = 0;
    end
    if (busy && sclLine && pulseCount == 4'd1) highWidth++;
    if (prevSdaOe && !sdaOe && sclLine) stopSeen = 1;
    if (!prevSdaOe && sdaOe && sclLine) badSdaFall = 1;
    prevSdaOe = sdaOe;
    if (done) doneSeen++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int gotCount;
  bit gotRec, gotFail;

  task automatic runRecovery(input int need, input int half, input int stretch,
                             input bit midStart);
    @(negedge clk);
    halfPeriod = 16'(half);
    tgtNeed = need; tgtEdges = 0; holdSda = (need > 0);
    stretchLen = stretch; stretchArm = (stretch > 0);
    firstLow = -1; curLow = 0; highWidth = 0; doneSeen = 0;
    sclDriven = 0; stopSeen = 0; badSdaFall = 0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) begin
      if (midStart && i == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    gotCount = pulseCount; gotRec = recovered; gotFail = failed;
    @(negedge clk);
  endtask

  task automatic testReset;
    chk(!busy && !done, "R7", "busy/done after reset", {busy, done}, 0);
    chk(!recovered && !failed, "R7", "flags after reset", {recovered, failed}, 0);
    chk(pulseCount == 0, "R7", "count after reset", pulseCount, 0);
    chk(!sclOe && !sdaOe, "R6", "lines released after reset", {sclOe, sdaOe}, 0);
  endtask

  task automatic testIdleBus;
    runRecovery(0, 4, 0, 0);
    chk(gotRec && !gotFail, "R1", "idle bus recovered", gotRec, 1);
    chk(gotCount == 0, "R1", "idle bus pulses", gotCount, 0);
    chk(!sclDriven && !stopSeen, "R1", "idle bus untouched", sclDriven, 0);
  endtask

  task automatic testPartialByte(input int need);
    runRecovery(need, 4, 0, 0);
    chk(gotCount == need, "R3", "pulses for partial byte", gotCount, need);
    chk(gotRec && !gotFail, "R3", "partial byte recovered", gotRec, 1);
    chk(stopSeen, "R5", "STOP after release", stopSeen, 1);
    chk(!badSdaFall, "R5", "SDA pulled low with SCL high", badSdaFall, 0);
  endtask

  task automatic testAckHold;
    runRecovery(9, 4, 0, 0);
    chk(gotCount == 9 && gotRec, "R4", "ack hold needs nine", gotCount, 9);
    chk(stopSeen, "R5", "STOP after ack release", stopSeen, 1);
  endtask

  task automatic testNeverFree;
    runRecovery(99, 4, 0, 0);
    chk(gotFail && !gotRec, "R4", "stuck bus failed", gotFail, 1);
    chk(gotCount == 9, "R4", "stuck bus pulses", gotCount, 9);
    chk(!sclOe && !sdaOe, "R4", "lines released after fail", {sclOe, sdaOe}, 0);
    chk(!stopSeen, "R4", "no STOP on fail", stopSeen, 0);
    repeat (20) @(negedge clk);
    chk(failed && !recovered, "R7", "fail flag held", failed, 1);
    runRecovery(0, 4, 0, 0);
    chk(!failed && recovered, "R7", "flags replaced on new run", failed, 0);
  endtask

  task automatic testTiming;
    runRecovery(3, 10, 0, 0);
    chk(firstLow == 10, "R2", "SCL low width", firstLow, 10);
    chk(highWidth == 12, "R2", "SCL high width", highWidth, 12);
    chk(gotCount == 3, "R3", "pulses at long period", gotCount, 3);
  endtask

  task automatic testStretch;
    runRecovery(3, 6, 15, 0);
    chk(highWidth == 8, "R8", "high width after stretch", highWidth, 8);
    chk(gotCount == 3 && gotRec, "R8", "pulses with stretch", gotCount, 3);
  endtask

  task automatic testStartIgnored;
    runRecovery(5, 4, 0, 1);
    chk(doneSeen == 1, "R7", "single done pulse", doneSeen, 1);
    chk(gotCount == 5 && gotRec, "R6", "start while busy ignored", gotCount, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleBus();
    testPartialByte(1);
    testPartialByte(5);
    testPartialByte(8);
    testAckHold();
    testNeverFree();
    testTiming();
    testStretch();
    testStartIgnored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule